// File: doc/BRIEF.md
# Core Module System Control Registers

This block is the system control register file of a processor core module. It sits on a simple 32-bit register bus: a byte address, a write strobe, write data, and a read data path that follows the address within the same cycle. Software uses it to read and program the oscillator, aux oscillator, SDRAM and init settings, to drive the boot remap and the status LED through a control word, to keep general and non-volatile flag bits, and to run a small interrupt section. That section has one software interrupt source and separate IRQ and FIQ enable masks.

The oscillator words are protected. A write to either of them lands only while a 16-bit unlock key sits in the lock register. Flag and enable registers have no plain write. Each has a set address that ORs the data in and a clear address that removes the bits set in the data, so several agents can change separate bits without a read-modify-write. A read-only byte window returns a memory description table whose density byte comes from a parameter. The IRQ and FIQ request lines are registered and follow the internal state one clock later.

Top module: `cm_ctrl_regs`

## Requirements
- R1: After reset these registers read as follows: oscillator (word 2) 0x01000048, aux oscillator (word 7) 0x0007FEFF, SDRAM (word 8) 0x00011122, init (word 9) 0x00000112. Every other register reads zero. remap_o is 1, and led_o, irq_o and fiq_o are 0.
- R2: The register word index is bus_addr[8:2], and bus_addr[1:0] are ignored for register accesses. The control word is 3, the lock word 5, the SDRAM word 8 and the init word 9. SDRAM and init accept any write and read back the value written.
- R3: A write to word 5 stores bus_wdata[15:0] only. Reading word 5 returns the stored key in bits 15:0, with bit 16 set exactly when the key equals 0xA05F.
- R4: A write to word 2 or word 7 takes effect only while the lock register holds 0xA05F. Otherwise the register keeps its value.
- R5: Flags: word 12 ORs the data in, word 13 clears the bits that are set in the data, and a read of word 12 returns the value. Non-volatile flags use words 14, 15 and 14 in the same way.
- R6: IRQ enable: word 18 sets bits and word 19 clears bits. FIQ enable: word 26 sets bits and word 27 clears bits. Reading word 18 or word 26 returns that mask.
- R7: The software interrupt level is one bit. Writing word 20 sets it and writing word 21 clears it, and each acts only when data bit 0 is 1. Words 20, 17 and 25 read the pending level (bit 0).
- R8: Word 16 reads pending AND IRQ enable. Word 24 reads pending AND FIQ enable.
- R9: irq_o is the OR of (pending AND IRQ enable), and fiq_o is the same using the FIQ enable. Each follows the register state one clock later.
- R10: The control word (3) is stored and read back. led_o equals control bit 0. remap_o equals the inverse of control bit 2, so remap_o = 1 means boot flash is mapped at address zero.
- R11: Byte offsets 0x100 to 0x1FF read {24'b0, table[bus_addr[7:1]]} from a 128-byte table. Entry 0 is 0x80, entry 1 is 0x08, entry 2 is 0x04, entry 3 is 0x0B, and entry 31 is a density code (0x20 for the default 128 MB). All other entries are 0. Writes to the window are ignored.
- R12: Words 32 to 35 (voltage control) and all unmapped words read zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| remap_o | output | 1 | 1: boot flash mapped at address zero |
| led_o | output | 1 | Status LED drive |
| irq_o | output | 1 | Registered IRQ request |
| fiq_o | output | 1 | Registered FIQ request |

## Verification
Register contents show up on bus_rdata in the same cycle the address is presented. A corrupted mask, flag or key is therefore visible on the first read of that word, and a wrong lock decision shows on the next read of the oscillator word. Errors in the interrupt state reach irq_o and fiq_o one clock after the register change, so the bench checks both the cycle right after the write (old value) and the cycle after that. A control bit stored wrongly appears on led_o or remap_o at the next falling edge after the write.

// File: rtl/cm_ctrl_regs.sv
module cm_ctrl_regs #(
  parameter int          ADDR_W     = 9,
  parameter logic [15:0] UNLOCK_KEY = 16'hA05F,
  parameter logic [31:0] OSC_RST    = 32'h0100_0048,
  parameter logic [31:0] AUX_RST    = 32'h0007_FEFF,
  parameter logic [31:0] SDRAM_RST  = 32'h0001_1122,
  parameter logic [31:0] INIT_RST   = 32'h0000_0112,
  parameter int          MEM_MB     = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              remap_o,
  output logic              led_o,
  output logic              irq_o,
  output logic              fiq_o
);

  localparam int WW = ADDR_W - 2;
  localparam logic [WW-1:0] W_OSC   = WW'(2);
  localparam logic [WW-1:0] W_CTRL  = WW'(3);
  localparam logic [WW-1:0] W_LOCK  = WW'(5);
  localparam logic [WW-1:0] W_AUX   = WW'(7);
  localparam logic [WW-1:0] W_SDRAM = WW'(8);
  localparam logic [WW-1:0] W_INIT  = WW'(9);
  localparam logic [WW-1:0] W_FLS   = WW'(12);
  localparam logic [WW-1:0] W_FLC   = WW'(13);
  localparam logic [WW-1:0] W_NVS   = WW'(14);
  localparam logic [WW-1:0] W_NVC   = WW'(15);
  localparam logic [WW-1:0] W_IRQST = WW'(16);
  localparam logic [WW-1:0] W_IRQRW = WW'(17);
  localparam logic [WW-1:0] W_IRQES = WW'(18);
  localparam logic [WW-1:0] W_IRQEC = WW'(19);
  localparam logic [WW-1:0] W_SWS   = WW'(20);
  localparam logic [WW-1:0] W_SWC   = WW'(21);
  localparam logic [WW-1:0] W_FIQST = WW'(24);
  localparam logic [WW-1:0] W_FIQRW = WW'(25);
  localparam logic [WW-1:0] W_FIQES = WW'(26);
  localparam logic [WW-1:0] W_FIQEC = WW'(27);
  localparam logic [7:0] DENSITY =
    (MEM_MB >= 256) ? 8'd64 : (MEM_MB >= 128) ? 8'd32 :
    (MEM_MB >= 64)  ? 8'd16 : (MEM_MB >= 32)  ? 8'd4 : 8'd2;

  logic [31:0] osc_q, aux_q, sdram_q, init_q, ctrl_q;
  logic [31:0] flags_q, nvflags_q, irq_en_q, fiq_en_q;
  logic [15:0] lock_q;
  logic        soft_q, irq_q, fiq_q;

  logic [WW-1:0] word;
  logic          spd_sel, unlocked;
  logic [31:0]   pend;
  logic          unused_bits;

  assign word        = bus_addr[ADDR_W-1:2];
  assign spd_sel     = bus_addr[ADDR_W-1:8] == (ADDR_W-8)'(1);
  assign unlocked    = lock_q == UNLOCK_KEY;
  assign pend        = {31'b0, soft_q};
  assign unused_bits = bus_addr[0];

  function automatic logic [7:0] spd_byte(input logic [6:0] idx);
    case (idx)
      7'd0:    spd_byte = 8'h80;
      7'd1:    spd_byte = 8'h08;
      7'd2:    spd_byte = 8'h04;
      7'd3:    spd_byte = 8'h0B;
      7'd31:   spd_byte = DENSITY;
      default: spd_byte = 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc_q     <= OSC_RST;
      aux_q     <= AUX_RST;
      sdram_q   <= SDRAM_RST;
      init_q    <= INIT_RST;
      ctrl_q    <= '0;
      lock_q    <= '0;
      flags_q   <= '0;
      nvflags_q <= '0;
      irq_en_q  <= '0;
      fiq_en_q  <= '0;
      soft_q    <= 1'b0;
    end else if (bus_wr) begin
      case (word)
        W_OSC:   if (unlocked) osc_q <= bus_wdata;
        W_AUX:   if (unlocked) aux_q <= bus_wdata;
        W_CTRL:  ctrl_q    <= bus_wdata;
        W_LOCK:  lock_q    <= bus_wdata[15:0];
        W_SDRAM: sdram_q   <= bus_wdata;
        W_INIT:  init_q    <= bus_wdata;
        W_FLS:   flags_q   <= flags_q | bus_wdata;
        W_FLC:   flags_q   <= flags_q & ~bus_wdata;
        W_NVS:   nvflags_q <= nvflags_q | bus_wdata;
        W_NVC:   nvflags_q <= nvflags_q & ~bus_wdata;
        W_IRQES: irq_en_q  <= irq_en_q | bus_wdata;
        W_IRQEC: irq_en_q  <= irq_en_q & ~bus_wdata;
        W_FIQES: fiq_en_q  <= fiq_en_q | bus_wdata;
        W_FIQEC: fiq_en_q  <= fiq_en_q & ~bus_wdata;
        W_SWS:   if (bus_wdata[0]) soft_q <= 1'b1;
        W_SWC:   if (bus_wdata[0]) soft_q <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= |(pend & irq_en_q);
      fiq_q <= |(pend & fiq_en_q);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (spd_sel) begin
      bus_rdata = {24'b0, spd_byte(bus_addr[7:1])};
    end else begin
      case (word)
        W_OSC:   bus_rdata = osc_q;
        W_CTRL:  bus_rdata = ctrl_q;
        W_LOCK:  bus_rdata = {15'b0, unlocked, lock_q};
        W_AUX:   bus_rdata = aux_q;
        W_SDRAM: bus_rdata = sdram_q;
        W_INIT:  bus_rdata = init_q;
        W_FLS:   bus_rdata = flags_q;
        W_NVS:   bus_rdata = nvflags_q;
        W_IRQST: bus_rdata = pend & irq_en_q;
        W_IRQRW: bus_rdata = pend;
        W_IRQES: bus_rdata = irq_en_q;
        W_SWS:   bus_rdata = pend;
        W_FIQST: bus_rdata = pend & fiq_en_q;
        W_FIQRW: bus_rdata = pend;
        W_FIQES: bus_rdata = fiq_en_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign remap_o = ~ctrl_q[2];
  assign led_o   = ctrl_q[0];
  assign irq_o   = irq_q;
  assign fiq_o   = fiq_q;

  a_r4_osc_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !unlocked && (word == W_OSC || word == W_AUX))
      |=> ($stable(osc_q) && $stable(aux_q)));

  a_r3_lock_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == W_LOCK) |=> (bus_rdata[15:0] == $past(bus_wdata[15:0]) || word != W_LOCK));

  a_r5_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == W_FLC) |=> ((flags_q & $past(bus_wdata)) == 32'b0));

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend & irq_en_q)) |=> !irq_o);

  a_r9_fiq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & fiq_en_q)) |=> fiq_o);

  a_r12_voltage_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word >= WW'(32) && word <= WW'(35))
      |=> ($stable(flags_q) && $stable(ctrl_q) && $stable(lock_q) && $stable(irq_en_q)));

endmodule

// File: tb/cm_ctrl_regs_tb_top.sv
module cm_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        remap_o, led_o, irq_o, fiq_o;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cm_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .remap_o(remap_o),
    .led_o(led_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  localparam int NV = 62;
  localparam logic [97:0] VEC [NV] = '{
    {"R1 ", 1'b0, 9'h008, 32'h0, 32'h0100_0048},
    {"R1 ", 1'b0, 9'h01C, 32'h0, 32'h0007_FEFF},
    {"R1 ", 1'b0, 9'h020, 32'h0, 32'h0001_1122},
    {"R1 ", 1'b0, 9'h024, 32'h0, 32'h0000_0112},
    {"R4 ", 1'b1, 9'h008, 32'h1234_5678, 32'h0},
    {"R4 ", 1'b0, 9'h008, 32'h0, 32'h0100_0048},
    {"R3 ", 1'b1, 9'h014, 32'hFFFF_A05F, 32'h0},
    {"R3 ", 1'b0, 9'h014, 32'h0, 32'h0001_A05F},
    {"R4 ", 1'b1, 9'h008, 32'h1234_5678, 32'h0},
    {"R4 ", 1'b0, 9'h008, 32'h0, 32'h1234_5678},
    {"R4 ", 1'b1, 9'h01C, 32'h0000_ABCD, 32'h0},
    {"R4 ", 1'b0, 9'h01C, 32'h0, 32'h0000_ABCD},
    {"R3 ", 1'b1, 9'h014, 32'h0000_1234, 32'h0},
    {"R3 ", 1'b0, 9'h014, 32'h0, 32'h0000_1234},
    {"R4 ", 1'b1, 9'h01C, 32'h1111_1111, 32'h0},
    {"R4 ", 1'b0, 9'h01C, 32'h0, 32'h0000_ABCD},
    {"R5 ", 1'b1, 9'h030, 32'hF0F0_000F, 32'h0},
    {"R5 ", 1'b1, 9'h030, 32'h0000_0300, 32'h0},
    {"R5 ", 1'b0, 9'h030, 32'h0, 32'hF0F0_030F},
    {"R5 ", 1'b1, 9'h034, 32'hF000_000F, 32'h0},
    {"R5 ", 1'b0, 9'h030, 32'h0, 32'h00F0_0300},
    {"R5 ", 1'b1, 9'h038, 32'h0000_00FF, 32'h0},
    {"R5 ", 1'b1, 9'h03C, 32'h0000_000F, 32'h0},
    {"R5 ", 1'b0, 9'h038, 32'h0, 32'h0000_00F0},
    {"R6 ", 1'b1, 9'h048, 32'h0000_000F, 32'h0},
    {"R6 ", 1'b1, 9'h04C, 32'h0000_0006, 32'h0},
    {"R6 ", 1'b0, 9'h048, 32'h0, 32'h0000_0009},
    {"R6 ", 1'b1, 9'h068, 32'h0000_00F0, 32'h0},
    {"R6 ", 1'b1, 9'h06C, 32'h0000_0010, 32'h0},
    {"R6 ", 1'b0, 9'h068, 32'h0, 32'h0000_00E0},
    {"R7 ", 1'b1, 9'h050, 32'hFFFF_FFFE, 32'h0},
    {"R7 ", 1'b0, 9'h050, 32'h0, 32'h0},
    {"R7 ", 1'b1, 9'h050, 32'h0000_0001, 32'h0},
    {"R7 ", 1'b0, 9'h050, 32'h0, 32'h0000_0001},
    {"R7 ", 1'b0, 9'h044, 32'h0, 32'h0000_0001},
    {"R7 ", 1'b0, 9'h064, 32'h0, 32'h0000_0001},
    {"R8 ", 1'b0, 9'h040, 32'h0, 32'h0000_0001},
    {"R8 ", 1'b0, 9'h060, 32'h0, 32'h0},
    {"R7 ", 1'b1, 9'h054, 32'hFFFF_FFFE, 32'h0},
    {"R7 ", 1'b0, 9'h050, 32'h0, 32'h0000_0001},
    {"R7 ", 1'b1, 9'h054, 32'h0000_0001, 32'h0},
    {"R7 ", 1'b0, 9'h050, 32'h0, 32'h0},
    {"R12", 1'b1, 9'h080, 32'hDEAD_BEEF, 32'h0},
    {"R12", 1'b0, 9'h080, 32'h0, 32'h0},
    {"R12", 1'b0, 9'h08C, 32'h0, 32'h0},
    {"R12", 1'b1, 9'h000, 32'h1234_5678, 32'h0},
    {"R12", 1'b0, 9'h000, 32'h0, 32'h0},
    {"R12", 1'b0, 9'h018, 32'h0, 32'h0},
    {"R12", 1'b0, 9'h008, 32'h0, 32'h1234_5678},
    {"R10", 1'b1, 9'h00C, 32'h0000_0005, 32'h0},
    {"R10", 1'b0, 9'h00C, 32'h0, 32'h0000_0005},
    {"R2 ", 1'b1, 9'h020, 32'h0000_0ABC, 32'h0},
    {"R2 ", 1'b0, 9'h020, 32'h0, 32'h0000_0ABC},
    {"R2 ", 1'b1, 9'h024, 32'h0000_0777, 32'h0},
    {"R2 ", 1'b0, 9'h024, 32'h0, 32'h0000_0777},
    {"R11", 1'b0, 9'h100, 32'h0, 32'h0000_0080},
    {"R11", 1'b0, 9'h102, 32'h0, 32'h0000_0008},
    {"R11", 1'b0, 9'h104, 32'h0, 32'h0000_0004},
    {"R11", 1'b0, 9'h13E, 32'h0, 32'h0000_0020},
    {"R11", 1'b0, 9'h1FE, 32'h0, 32'h0},
    {"R11", 1'b1, 9'h100, 32'hFFFF_FFFF, 32'h0},
    {"R11", 1'b0, 9'h100, 32'h0, 32'h0000_0080}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [8:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state at the ports
    check("R1 remap", 32'(remap_o), 32'd1);
    check("R1 led", 32'(led_o), 32'd0);
    check("R1 irq", 32'(irq_o), 32'd0);
    check("R1 fiq", 32'(fiq_o), 32'd0);
    rd("R1 ctrl", 9'h00C, 32'h0);
    rd("R1 lock", 9'h014, 32'h0);
    rd("R1 irqen", 9'h048, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][73]) wr(VEC[i][72:64], VEC[i][63:32]);
      else            rd($sformatf("%s vec%0d", VEC[i][97:74], i), VEC[i][72:64], VEC[i][31:0]);
    end

    // R2 low address bits ignored
    rd("R2 misaligned", 9'h022, 32'h0000_0ABC);

    // R10 control drives LED and remap (ctrl = 5 from table)
    check("R10 led", 32'(led_o), 32'd1);
    check("R10 remap", 32'(remap_o), 32'd0);
    wr(9'h00C, 32'h0);
    check("R10 led off", 32'(led_o), 32'd0);
    check("R10 remap back", 32'(remap_o), 32'd1);

    // R9 registered request lines (irq_en = 9, fiq_en = E0, soft = 0)
    wr(9'h050, 32'h1);
    check("R9 irq lag", 32'(irq_o), 32'd0);
    @(negedge clk);
    check("R9 irq up", 32'(irq_o), 32'd1);
    check("R9 fiq masked", 32'(fiq_o), 32'd0);
    wr(9'h068, 32'h1);
    @(negedge clk);
    check("R9 fiq up", 32'(fiq_o), 32'd1);
    rd("R8 fiq status", 9'h060, 32'h1);
    wr(9'h04C, 32'h1);
    @(negedge clk);
    check("R9 irq down", 32'(irq_o), 32'd0);
    check("R9 fiq held", 32'(fiq_o), 32'd1);
    wr(9'h054, 32'h1);
    @(negedge clk);
    check("R9 fiq down", 32'(fiq_o), 32'd0);

    // R1 reset again after activity
    wr(9'h00C, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd("R1 osc again", 9'h008, 32'h0100_0048);
    rd("R1 aux again", 9'h01C, 32'h0007_FEFF);
    rd("R1 flags again", 9'h030, 32'h0);
    rd("R1 fiqen again", 9'h068, 32'h0);
    check("R1 led again", 32'(led_o), 32'd0);

    summary();
  end
endmodule